// File: doc/BRIEF.md
# Content-independent frame stripping controller

This block sits on the receive path of a token ring station and decides, frame by frame, whether the station removes an arriving frame or passes it downstream. It does not look at the address fields to make that choice. It keeps a count of the frames the station has put on the ring since it last captured the token. While that count is nonzero, every arriving frame except a token is removed. Each error-free removed frame retires one count. When the count is zero, the block removes only frames that the address comparator flags as carrying this station's own source address.

After its last frame, the station sends a short void frame. When that void frame returns error-free with the station's own source address, the count is forced back to zero. This ends the stripping epoch even if errored returns left the count too high. The transmit side reports frame, void and token events. A second output tells the transmitter whether a void frame has gone out since its last frame, so that the token may be released.

The decision is registered. It is visible one clock after the start-of-frame strobe, which is well inside the first bytes of the frame, so the remnant left on the ring stays far shorter than a minimum-size frame. It rises one clock after an own-address hit. It falls one clock after the end-of-frame strobe.

Top module: `strip_ctl`

## Requirements
- R1: After reset, `pend_cnt` is 0, `strip` is 0 and `token_ok` is 0.
- R2: Each cycle with `tx_frame_sent` high and no decrement or clear in that cycle raises `pend_cnt` by one. At 2^CNT_W-1 it holds instead of wrapping. The default CNT_W of 10 gives 1023, which covers 560 outstanding frames. `tx_void_sent` and `tx_token_sent` never change the count.
- R3: A frame start (`rx_sof`) seen while `pend_cnt` is nonzero and the frame is not a token drives `strip` high from the next cycle. `strip` stays high until the cycle after `rx_eof`. Frame kind encoding on `rx_kind`: 2'b00 normal, 2'b01 void, 2'b10 token, 2'b11 handled as normal.
- R4: A frame start seen while `pend_cnt` is 0 leaves `strip` low. An `rx_sa_hit` pulse inside a non-token frame, before its end, raises `strip` from the next cycle. `strip` then stays high until the cycle after `rx_eof`.
- R5: At `rx_eof`, a removed frame with `rx_ok` high lowers `pend_cnt` by one. A removed frame with `rx_ok` low leaves the count unchanged. A repeated frame leaves the count unchanged. The count never goes below 0.
- R6: An end of a void frame with `rx_ok` high and an own-address hit during that frame sets `pend_cnt` to 0 in the next cycle. This holds from any value of the count, and it overrides a same-cycle `tx_frame_sent`.
- R7: When `tx_frame_sent` and a decrement from R5 fall in the same cycle, `pend_cnt` is unchanged.
- R8: A token (`rx_kind` 2'b10) is never stripped, even with an own-address hit, and never changes `pend_cnt`.
- R9: `token_ok` goes high the cycle after `tx_void_sent`. It goes low the cycle after `tx_frame_sent` or `tx_token_sent`. Clearing wins when both kinds of event occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_frame_sent | input | 1 | One-cycle pulse per frame transmitted |
| tx_void_sent | input | 1 | One-cycle pulse when the void frame is transmitted |
| tx_token_sent | input | 1 | One-cycle pulse when the token is released |
| rx_sof | input | 1 | Start of a received frame |
| rx_kind | input | 2 | Kind of the received frame, valid with `rx_sof` |
| rx_sa_hit | input | 1 | Pulse: source address equals own address |
| rx_eof | input | 1 | End of the received frame |
| rx_ok | input | 1 | Frame was error-free, valid with `rx_eof` |
| strip | output | 1 | High while the current frame is to be removed |
| pend_cnt | output | CNT_W | Frames outstanding for stripping |
| token_ok | output | 1 | A void frame has been sent since the last frame |

## Verification
The bench sweeps every combination of starting count (zero, one, middle, saturated), frame kind, own-address hit and error flag. It compares the strip level at the start, after the hit and after the end, and the resulting count, against an arithmetic model.

Three kinds of fault would show up here:
- A design that decremented on errored frames would let foreign frames pass while its own frames still circulate.
- A design that wrapped the counter or went below zero would strip the whole ring indefinitely.
- A design that let a token be stripped would destroy the ring's right to transmit.

The same-cycle collisions of increment with decrement, and of increment with the own-void clear, are driven on purpose, because a wrong priority there leaves a count that never returns to zero.

// File: rtl/fs_pkg.sv
package fs_pkg;

    typedef enum logic [1:0] {
        FT_NORMAL = 2'b00,
        FT_VOID   = 2'b01,
        FT_TOKEN  = 2'b10,
        FT_RSVD   = 2'b11
    } ftype_e;

    typedef struct packed {
        logic   sof;
        logic   eof;
        logic   ok;
        logic   sa_hit;
        ftype_e kind;
    } rx_evt_t;

    typedef enum logic [1:0] {
        CNT_HOLD,
        CNT_UP,
        CNT_DOWN,
        CNT_CLEAR
    } cnt_op_e;

    // clear beats everything; simultaneous up and down cancel
    function automatic cnt_op_e pick_op(logic up, logic down, logic clr);
        cnt_op_e op;
        if (clr)              op = CNT_CLEAR;
        else if (up && down)  op = CNT_HOLD;
        else if (up)          op = CNT_UP;
        else if (down)        op = CNT_DOWN;
        else                  op = CNT_HOLD;
        return op;
    endfunction

    function automatic logic is_token(ftype_e k);
        return k == FT_TOKEN;
    endfunction

endpackage

// File: rtl/strip_count.sv
module strip_count
    import fs_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_op_e          op,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_ZERO;
        end else begin
            unique case (op)
                CNT_CLEAR: cnt_q <= CNT_ZERO;
                CNT_UP:    if (cnt_q != CNT_MAX)  cnt_q <= cnt_q + CNT_ONE;
                CNT_DOWN:  if (cnt_q != CNT_ZERO) cnt_q <= cnt_q - CNT_ONE;
                default:   cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/strip_decide.sv
module strip_decide
    import fs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  rx_evt_t evt,
    input  logic    cnt_nz,
    output logic    strip,
    output logic    dec_req,
    output logic    clr_req
);
    logic   in_frame_q;
    logic   strip_q;
    logic   own_q;
    ftype_e kind_q;
    logic   frame_end;
    logic   own_void;

    assign frame_end = evt.eof && in_frame_q;
    assign own_void  = own_q && (kind_q == FT_VOID);
    assign clr_req   = frame_end && evt.ok && own_void;
    assign dec_req   = frame_end && evt.ok && strip_q && !own_void;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            strip_q    <= 1'b0;
            own_q      <= 1'b0;
            kind_q     <= FT_NORMAL;
        end else if (evt.sof) begin
            in_frame_q <= 1'b1;
            kind_q     <= evt.kind;
            own_q      <= 1'b0;
            strip_q    <= cnt_nz && !is_token(evt.kind);
        end else if (frame_end) begin
            in_frame_q <= 1'b0;
            strip_q    <= 1'b0;
            own_q      <= 1'b0;
        end else if (evt.sa_hit && in_frame_q && !is_token(kind_q)) begin
            strip_q    <= 1'b1;
            own_q      <= 1'b1;
        end
    end

    assign strip = strip_q;
endmodule

// File: rtl/token_gate.sv
module token_gate (
    input  logic clk,
    input  logic rst,
    input  logic frame_sent,
    input  logic void_sent,
    input  logic token_sent,
    output logic release_ok
);
    logic ok_q;

    always_ff @(posedge clk) begin
        if (rst)                       ok_q <= 1'b0;
        else if (frame_sent || token_sent) ok_q <= 1'b0;
        else if (void_sent)            ok_q <= 1'b1;
    end

    assign release_ok = ok_q;
endmodule

// File: rtl/strip_ctl.sv
module strip_ctl
    import fs_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_frame_sent,
    input  logic             tx_void_sent,
    input  logic             tx_token_sent,
    input  logic             rx_sof,
    input  logic [1:0]       rx_kind,
    input  logic             rx_sa_hit,
    input  logic             rx_eof,
    input  logic             rx_ok,
    output logic             strip,
    output logic [CNT_W-1:0] pend_cnt,
    output logic             token_ok
);
    rx_evt_t          evt;
    cnt_op_e          op;
    logic             dec_req;
    logic             clr_req;
    logic [CNT_W-1:0] cnt_w;

    always_comb begin
        evt.sof    = rx_sof;
        evt.eof    = rx_eof;
        evt.ok     = rx_ok;
        evt.sa_hit = rx_sa_hit;
        evt.kind   = ftype_e'(rx_kind);
    end

    assign op = pick_op(tx_frame_sent, dec_req, clr_req);

    strip_count #(.CNT_W(CNT_W)) u_count (
        .clk (clk),
        .rst (rst),
        .op  (op),
        .cnt (cnt_w)
    );

    strip_decide u_decide (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .cnt_nz  (|cnt_w),
        .strip   (strip),
        .dec_req (dec_req),
        .clr_req (clr_req)
    );

    token_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .frame_sent (tx_frame_sent),
        .void_sent  (tx_void_sent),
        .token_sent (tx_token_sent),
        .release_ok (token_ok)
    );

    assign pend_cnt = cnt_w;
endmodule

// File: rtl/strip_ctl_chk.sv
module strip_ctl_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_frame_sent,
    input logic             tx_token_sent,
    input logic             rx_sof,
    input logic [1:0]       rx_kind,
    input logic             strip,
    input logic [CNT_W-1:0] pend_cnt,
    input logic             token_ok,
    input logic             dec_req,
    input logic             clr_req
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // R2
    up_step_chk: assert property (@(posedge clk) disable iff (rst)
        tx_frame_sent && !dec_req && !clr_req && pend_cnt != CMAX
        |=> pend_cnt == $past(pend_cnt) + CONE);

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pend_cnt == '0 && !tx_frame_sent |=> pend_cnt == '0);

    // R6
    void_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> pend_cnt == '0);

    // R7
    cancel_chk: assert property (@(posedge clk) disable iff (rst)
        tx_frame_sent && dec_req && !clr_req |=> $stable(pend_cnt));

    // R3
    count_strip_chk: assert property (@(posedge clk) disable iff (rst)
        rx_sof && pend_cnt != '0 && rx_kind != 2'b10 |=> strip);

    // R8
    token_pass_chk: assert property (@(posedge clk) disable iff (rst)
        rx_sof && rx_kind == 2'b10 |=> !strip);

    // R9
    token_ok_drop_chk: assert property (@(posedge clk) disable iff (rst)
        tx_token_sent |=> !token_ok);
endmodule

bind strip_ctl strip_ctl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .tx_frame_sent (tx_frame_sent),
    .tx_token_sent (tx_token_sent),
    .rx_sof        (rx_sof),
    .rx_kind       (rx_kind),
    .strip         (strip),
    .pend_cnt      (pend_cnt),
    .token_ok      (token_ok),
    .dec_req       (dec_req),
    .clr_req       (clr_req)
);

// File: tb/strip_ctl_bench.sv
`timescale 1ns/100ps
module strip_ctl_bench;
    localparam int W    = 3;
    localparam int CMAX = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tx_frame_sent = 1'b0;
    logic         tx_void_sent  = 1'b0;
    logic         tx_token_sent = 1'b0;
    logic         rx_sof = 1'b0;
    logic [1:0]   rx_kind = 2'b00;
    logic         rx_sa_hit = 1'b0;
    logic         rx_eof = 1'b0;
    logic         rx_ok = 1'b0;
    logic         strip;
    logic [W-1:0] pend_cnt;
    logic         token_ok;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    strip_ctl #(.CNT_W(W)) u_strip_ctl (
        .clk (clk), .rst (rst),
        .tx_frame_sent (tx_frame_sent), .tx_void_sent (tx_void_sent),
        .tx_token_sent (tx_token_sent),
        .rx_sof (rx_sof), .rx_kind (rx_kind), .rx_sa_hit (rx_sa_hit),
        .rx_eof (rx_eof), .rx_ok (rx_ok),
        .strip (strip), .pend_cnt (pend_cnt), .token_ok (token_ok)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_tx(input int n);
        for (int i = 0; i < n; i++) begin
            tx_frame_sent = 1'b1;
            @(negedge clk);
            tx_frame_sent = 1'b0;
        end
    endtask

    task automatic rx_frame(input int kind, input bit sa, input bit ok, input bit inc,
                            output int s0, output int s1, output int s2, output int c);
        rx_sof = 1'b1; rx_kind = kind[1:0];
        @(negedge clk);
        rx_sof = 1'b0;
        s0 = strip;
        rx_sa_hit = sa;
        @(negedge clk);
        rx_sa_hit = 1'b0;
        s1 = strip;
        rx_eof = 1'b1; rx_ok = ok; tx_frame_sent = inc;
        @(negedge clk);
        rx_eof = 1'b0; rx_ok = 1'b0; tx_frame_sent = 1'b0;
        s2 = strip;
        c  = pend_cnt;
    endtask

    initial begin
        int s0, s1, s2, c;
        int starts[4] = '{0, 1, 3, 7};
        @(negedge clk);
        do_reset();
        // R1
        chk("R1 count", pend_cnt, 0);
        chk("R1 strip", strip, 0);
        chk("R1 token_ok", token_ok, 0);

        // R2 increment and saturation sweep
        for (int n = 0; n <= CMAX + 2; n++) begin
            do_reset();
            send_tx(n);
            chk("R2 count after sends", pend_cnt, (n > CMAX) ? CMAX : n);
        end
        do_reset();
        tx_void_sent = 1'b1; @(negedge clk); tx_void_sent = 1'b0;
        tx_token_sent = 1'b1; @(negedge clk); tx_token_sent = 1'b0;
        chk("R2 void/token no count", pend_cnt, 0);

        // sweep count x kind x own-hit x error
        for (int si = 0; si < 4; si++) begin
            for (int k = 0; k < 4; k++) begin
                for (int sa = 0; sa < 2; sa++) begin
                    for (int ok = 0; ok < 2; ok++) begin
                        int st, e0, e1, ec;
                        bit tok;
                        st  = starts[si];
                        tok = (k == 2);
                        do_reset();
                        send_tx(st);
                        e0 = (st > 0 && !tok) ? 1 : 0;
                        e1 = (e0 == 1 || (sa == 1 && !tok)) ? 1 : 0;
                        if (k == 1 && sa == 1 && ok == 1) ec = 0;
                        else if (e1 == 1 && ok == 1 && st > 0) ec = st - 1;
                        else ec = st;
                        rx_frame(k, sa[0], ok[0], 1'b0, s0, s1, s2, c);
                        chk(tok ? "R8 strip at start" : (st > 0 ? "R3 strip at start" : "R4 strip at start"), s0, e0);
                        chk(tok ? "R8 strip after hit" : "R4 strip after hit", s1, e1);
                        chk("R3 strip after end", s2, 0);
                        chk((k == 1 && sa == 1) ? "R6 count" : (tok ? "R8 count" : "R5 count"), c, ec);
                    end
                end
            end
        end

        // R7 increment and decrement together
        do_reset();
        send_tx(2);
        rx_frame(0, 1'b0, 1'b1, 1'b1, s0, s1, s2, c);
        chk("R7 inc+dec cancel", c, 2);
        // R6 own void beats same-cycle increment
        rx_frame(1, 1'b1, 1'b1, 1'b1, s0, s1, s2, c);
        chk("R6 clear beats inc", c, 0);
        // R5 errored own void: stripped, no clear, no change
        send_tx(3);
        rx_frame(1, 1'b1, 1'b0, 1'b0, s0, s1, s2, c);
        chk("R5 errored void keeps count", c, 3);

        // R9 token release gate
        do_reset();
        tx_void_sent = 1'b1; @(negedge clk); tx_void_sent = 1'b0;
        chk("R9 set by void", token_ok, 1);
        send_tx(1);
        chk("R9 cleared by frame", token_ok, 0);
        tx_void_sent = 1'b1; @(negedge clk); tx_void_sent = 1'b0;
        tx_token_sent = 1'b1; @(negedge clk); tx_token_sent = 1'b0;
        chk("R9 cleared by token", token_ok, 0);
        tx_void_sent = 1'b1; tx_frame_sent = 1'b1; @(negedge clk);
        tx_void_sent = 1'b0; tx_frame_sent = 1'b0;
        chk("R9 clear wins", token_ok, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule